// File: doc/BRIEF.md
# Four-Channel H-Bridge Command Logic

This block converts digital motor commands into the gate-enable levels of four H-bridges. Every bridge has two legs. The OUT+ leg has upper switch A and lower switch B. The OUT- leg has upper switch D and lower switch C. Channel 0 drives a spindle motor from a three-level command. Here that command arrives as a 2-bit code. Channels 1 to 3 each take a separate forward and reverse bit. When both bits of a channel are equal, the channel brakes: the motor is shorted through both lower switches.

Two sources override every command. A mute input and an internal over-temperature flag switch every switch of every bridge off (high impedance). The over-temperature flag is derived with hysteresis from a digital temperature code in degrees Celsius.

Each leg is driven by a small sequencer. A switch may only turn on after its leg has been fully off for a configurable dead time. A switch that a command turned on stays on for at least a minimum pulse width. That width is 300 ns, converted to clock cycles from the clock period parameter. Mute and thermal shutdown may cut a pulse short, because turning a switch off can never cause shoot-through.

Top module: `qbr_top`

## Requirements
- R1: On a pair channel, forward=1 and reverse=0 settles to A and C on, B and D off (OUT+ high, OUT- low).
- R2: On a pair channel, forward=0 and reverse=1 settles to B and D on, A and C off (OUT+ low, OUT- high).
- R3: On a pair channel, equal forward and reverse bits (00 or 11) settle to brake: B and C on, A and D off.
- R4: The spindle code is decoded as follows: 2'b01 is forward (as R1), 2'b00 is reverse (as R2), and 2'b10 (open) and 2'b11 are brake (as R3).
- R5: If mute_i is 1 at a clock edge, all sixteen switch outputs are 0 after that edge, brake included. After mute is released, the commanded states return.
- R6: The upper and lower switch of one leg are never on together. After a leg turns off, neither of its switches turns on until the leg has been off for at least DEAD_CYC cycles (default 4).
- R7: tsd_o becomes 1 on the edge after temp_i >= 150 is seen. It becomes 0 on the edge after temp_i <= 130 is seen, and it holds its value for codes in between. While tsd_o is 1, all switch outputs are 0 from the next edge on.
- R8: A switch turned on by a command stays on for at least ceil(300 ns / clock period) cycles (15 at 20 ns), unless mute or thermal shutdown turns it off.
- R9: During reset all switch outputs and tsd_o are 0. No switch turns on during the first DEAD_CYC-1 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_i | input | NUM_PAIR (3) | Forward bit of pair channels 1..3 (bit k is channel k+1) |
| rev_i | input | NUM_PAIR (3) | Reverse bit of pair channels 1..3 |
| spin_cmd_i | input | 2 | Spindle code: 01 forward, 00 reverse, 10/11 brake |
| mute_i | input | 1 | Forces every switch off |
| temp_i | input | TEMP_W (8) | Die temperature code, degrees Celsius |
| sw_a_o | output | NCH (4) | Upper switch of the OUT+ leg, one bit per channel |
| sw_b_o | output | NCH (4) | Lower switch of the OUT+ leg |
| sw_c_o | output | NCH (4) | Lower switch of the OUT- leg |
| sw_d_o | output | NCH (4) | Upper switch of the OUT- leg |
| tsd_o | output | 1 | Thermal shutdown flag |

## Verification
Directed patterns apply each pair combination and each spindle code to all channels, plus one mixed pattern. In the mixed pattern each channel sits in a different state, so a swapped channel index or a swapped leg shows up. Single transitions from brake to forward and straight back measure the dead-time gap and the minimum pulse. These separate a leg sequencer that switches directly from one that passes through off, and one that releases a pulse early from one that holds it. Temperature steps at 149, 150, 131 and 130 tell a true hysteresis apart from a single threshold. Seeded random segments then mix commands, mute and hot codes, while a cycle monitor checks gap, pulse and override timing at every switch edge.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

  // Applied state of one half-bridge leg.
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  // Direction a whole bridge is commanded to.
  typedef enum logic [1:0] {
    DIR_BRAKE = 2'd0,
    DIR_FWD   = 2'd1,
    DIR_REV   = 2'd2
  } dir_e;

  localparam logic [1:0] SPIN_REV = 2'b00;
  localparam logic [1:0] SPIN_FWD = 2'b01;

  // Pair channel: exactly one bit set selects a direction, equal bits brake.
  function automatic dir_e pair_dir(input logic fwd, input logic rev);
    dir_e d;
    case ({fwd, rev})
      2'b10:   d = DIR_FWD;
      2'b01:   d = DIR_REV;
      default: d = DIR_BRAKE;
    endcase
    return d;
  endfunction

  // Spindle channel: open (10) and the unused code (11) both brake.
  function automatic dir_e spin_dir(input logic [1:0] code);
    dir_e d;
    case (code)
      SPIN_FWD: d = DIR_FWD;
      SPIN_REV: d = DIR_REV;
      default:  d = DIR_BRAKE;
    endcase
    return d;
  endfunction

  // True when a state entered count+1 edges ago has lasted 'need' cycles.
  function automatic logic span_reached(input logic [31:0] count,
                                        input logic [31:0] need);
    return (count + 32'd1) >= need;
  endfunction

  // Minimum pulse width rounded up to whole clock cycles.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

endpackage

// File: rtl/qbr_thermal.sv
module qbr_thermal #(
  parameter int TEMP_W    = 8,
  parameter int HOT_CODE  = 150,
  parameter int COOL_CODE = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              tsd_o
);
  localparam logic [TEMP_W-1:0] HOT_C  = TEMP_W'(HOT_CODE);
  localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(COOL_CODE);

  logic hot_hit;
  logic cool_hit;
  logic tsd_q;

  assign hot_hit  = (temp_i >= HOT_C);
  assign cool_hit = (temp_i <= COOL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tsd_q <= 1'b0;
    else if (hot_hit)  tsd_q <= 1'b1;
    else if (cool_hit) tsd_q <= 1'b0;
  end

  assign tsd_o = tsd_q;
endmodule

// File: rtl/qbr_leg.sv
module qbr_leg
  import qbr_pkg::*;
#(
  parameter int DEAD_CYC  = 4,
  parameter int MINPW_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic want_hi_i,
  output logic up_o,
  output logic lo_o
);
  localparam int CNT_MAX = (DEAD_CYC > MINPW_CYC) ? DEAD_CYC : MINPW_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(CNT_MAX);

  leg_e          state_q, state_d;
  leg_e          goal;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          hold_done;
  logic          dead_done;

  assign goal      = want_hi_i ? LEG_HI : LEG_LO;
  assign hold_done = span_reached(32'(cnt_q), 32'(MINPW_CYC));
  assign dead_done = span_reached(32'(cnt_q), 32'(DEAD_CYC));
  assign cnt_inc   = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CW'(1);

  // Every change passes through OFF: on -> off after the hold, off -> on after the gap.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_inc;
    if (kill_i) begin
      state_d = LEG_OFF;
      if (state_q != LEG_OFF) cnt_d = '0;
    end else if (state_q == LEG_OFF) begin
      if (dead_done) begin
        state_d = goal;
        cnt_d   = '0;
      end
    end else if (state_q != goal && hold_done) begin
      state_d = LEG_OFF;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LEG_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign up_o = (state_q == LEG_HI);
  assign lo_o = (state_q == LEG_LO);
endmodule

// File: rtl/qbr_top.sv
module qbr_top
  import qbr_pkg::*;
#(
  parameter int NUM_PAIR      = 3,
  parameter int CLK_PERIOD_NS = 20,
  parameter int MIN_PULSE_NS  = 300,
  parameter int DEAD_CYC      = 4,
  parameter int TEMP_W        = 8,
  parameter int HOT_CODE      = 150,
  parameter int COOL_CODE     = 130
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PAIR-1:0] fwd_i,
  input  logic [NUM_PAIR-1:0] rev_i,
  input  logic [1:0]          spin_cmd_i,
  input  logic                mute_i,
  input  logic [TEMP_W-1:0]   temp_i,
  output logic [NUM_PAIR:0]   sw_a_o,
  output logic [NUM_PAIR:0]   sw_b_o,
  output logic [NUM_PAIR:0]   sw_c_o,
  output logic [NUM_PAIR:0]   sw_d_o,
  output logic                tsd_o
);
  localparam int NCH       = NUM_PAIR + 1;
  localparam int NLEG      = 2 * NCH;
  localparam int MINPW_CYC = ns_to_cycles(MIN_PULSE_NS, CLK_PERIOD_NS);

  logic            kill;
  logic [NLEG-1:0] leg_want_hi;
  logic [NLEG-1:0] leg_up;
  logic [NLEG-1:0] leg_lo;

  qbr_thermal #(
    .TEMP_W   (TEMP_W),
    .HOT_CODE (HOT_CODE),
    .COOL_CODE(COOL_CODE)
  ) u_thermal (
    .clk   (clk),
    .rst_n (rst_n),
    .temp_i(temp_i),
    .tsd_o (tsd_o)
  );

  assign kill = mute_i | tsd_o;

  // Leg 2*ch is the OUT+ leg (A/B), leg 2*ch+1 the OUT- leg (D/C).
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dir_e dir_w;
    if (ch == 0) begin : g_spin
      assign dir_w = spin_dir(spin_cmd_i);
    end else begin : g_pair
      assign dir_w = pair_dir(fwd_i[ch-1], rev_i[ch-1]);
    end
    assign leg_want_hi[2*ch]   = (dir_w == DIR_FWD);
    assign leg_want_hi[2*ch+1] = (dir_w == DIR_REV);

    assign sw_a_o[ch] = leg_up[2*ch];
    assign sw_b_o[ch] = leg_lo[2*ch];
    assign sw_d_o[ch] = leg_up[2*ch+1];
    assign sw_c_o[ch] = leg_lo[2*ch+1];
  end

  for (genvar lg = 0; lg < NLEG; lg++) begin : g_leg
    qbr_leg #(
      .DEAD_CYC (DEAD_CYC),
      .MINPW_CYC(MINPW_CYC)
    ) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill_i   (kill),
      .want_hi_i(leg_want_hi[lg]),
      .up_o     (leg_up[lg]),
      .lo_o     (leg_lo[lg])
    );
  end
endmodule

// File: rtl/qbr_chk.sv
module qbr_chk #(
  parameter int NLEG      = 8,
  parameter int DEAD_CYC  = 4,
  parameter int MINPW_CYC = 15,
  parameter int TEMP_W    = 8,
  parameter int HOT_CODE  = 150,
  parameter int COOL_CODE = 130
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mute_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic              tsd_i,
  input logic [NLEG-1:0]   up_i,
  input logic [NLEG-1:0]   lo_i
);
  localparam int RMAX = (DEAD_CYC > MINPW_CYC) ? DEAD_CYC : MINPW_CYC;
  localparam int RW   = $clog2(RMAX + 1);
  localparam logic [RW-1:0] R_TOP   = RW'(RMAX);
  localparam logic [RW-1:0] DEAD_R  = RW'(DEAD_CYC);
  localparam logic [RW-1:0] MINPW_R = RW'(MINPW_CYC);
  localparam logic [TEMP_W-1:0] HOT_C  = TEMP_W'(HOT_CODE);
  localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(COOL_CODE);

  logic [NLEG-1:0] on_w;
  logic [RW-1:0]   off_run [NLEG];
  logic [RW-1:0]   on_run  [NLEG];

  assign on_w = up_i | lo_i;

  // Run-length counters replace long $past windows.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLEG; i++) begin
        off_run[i] <= DEAD_R;
        on_run[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NLEG; i++) begin
        if (on_w[i]) begin
          off_run[i] <= '0;
          on_run[i]  <= (on_run[i] == R_TOP) ? on_run[i] : on_run[i] + RW'(1);
        end else begin
          on_run[i]  <= '0;
          off_run[i] <= (off_run[i] == R_TOP) ? off_run[i] : off_run[i] + RW'(1);
        end
      end
    end
  end

  p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i & lo_i) == '0);

  p_mute_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |=> (on_w == '0));

  p_tsd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_i |=> (on_w == '0));

  p_tsd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i >= HOT_C) |=> tsd_i);

  p_tsd_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i <= COOL_C) |=> !tsd_i);

  p_tsd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i > COOL_C && temp_i < HOT_C) |=> (tsd_i == $past(tsd_i)));

  for (genvar g = 0; g < NLEG; g++) begin : g_leg_chk
    p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_w[g]) |-> (off_run[g] >= DEAD_R));

    p_min_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(on_w[g]) && !$past(mute_i) && !$past(tsd_i)) |-> (on_run[g] >= MINPW_R));
  end
endmodule

bind qbr_top qbr_chk #(
  .NLEG     (NLEG),
  .DEAD_CYC (DEAD_CYC),
  .MINPW_CYC(MINPW_CYC),
  .TEMP_W   (TEMP_W),
  .HOT_CODE (HOT_CODE),
  .COOL_CODE(COOL_CODE)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mute_i(mute_i),
  .temp_i(temp_i),
  .tsd_i (tsd_o),
  .up_i  (leg_up),
  .lo_i  (leg_lo)
);

// File: tb/qbr_top_test.sv
module qbr_top_test;
  localparam int CLK_NS = 20;
  localparam int DEAD   = 4;
  localparam int MINPW  = (300 + CLK_NS - 1) / CLK_NS;
  localparam int SETTLE = 2 * (DEAD + MINPW) + 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fwd_i = '0;
  logic [2:0] rev_i = '0;
  logic [1:0] spin_cmd_i = 2'b10;
  logic       mute_i = 1'b0;
  logic [7:0] temp_i = 8'd25;
  logic [3:0] sw_a_o, sw_b_o, sw_c_o, sw_d_o;
  logic       tsd_o;

  int nvec = 0;
  int nbad = 0;

  qbr_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_i     (fwd_i),
    .rev_i     (rev_i),
    .spin_cmd_i(spin_cmd_i),
    .mute_i    (mute_i),
    .temp_i    (temp_i),
    .sw_a_o    (sw_a_o),
    .sw_b_o    (sw_b_o),
    .sw_c_o    (sw_c_o),
    .sw_d_o    (sw_d_o),
    .tsd_o     (tsd_o)
  );

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [15:0] pack_sw();
    return {sw_a_o, sw_b_o, sw_c_o, sw_d_o};
  endfunction

  // Expected switches from terminal levels: a driven OUT+ high means A on,
  // a driven OUT- high means D on; a terminal that is not high is pulled low.
  function automatic logic [15:0] expect_sw(input logic [2:0] f, input logic [2:0] r,
                                            input logic [1:0] sp);
    logic [3:0] a, b, c, d;
    for (int ch = 0; ch < 4; ch++) begin
      logic plus_hi, minus_hi;
      if (ch == 0) begin
        plus_hi  = (sp == 2'b01);
        minus_hi = (sp == 2'b00);
      end else begin
        plus_hi  = f[ch-1] & ~r[ch-1];
        minus_hi = r[ch-1] & ~f[ch-1];
      end
      a[ch] = plus_hi;
      b[ch] = ~plus_hi;
      d[ch] = minus_hi;
      c[ch] = ~minus_hi;
    end
    return {a, b, c, d};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ge(input string req, input int act, input int minv);
    nvec++;
    if (act < minv) begin
      nbad++;
      $display("FAIL %s: actual %0d expected at least %0d at %0t", req, act, minv, $time);
    end
  endtask

  task automatic settle_check(input string req);
    repeat (SETTLE) @(negedge clk);
    check(req, pack_sw(), expect_sw(fwd_i, rev_i, spin_cmd_i));
  endtask

  // Cycle monitor, sampled 5 ns after each rising edge.
  int   off_run [8];
  int   on_run  [8];
  logic prev_on [8];
  logic tsd_prev;
  logic tsd_model;

  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        off_run[i] = DEAD;
        on_run[i]  = 0;
        prev_on[i] = 1'b0;
      end
      tsd_prev  = 1'b0;
      tsd_model = 1'b0;
    end else begin
      logic kill_now;
      kill_now = mute_i | tsd_prev;
      if (temp_i >= 8'd150)      tsd_model = 1'b1;
      else if (temp_i <= 8'd130) tsd_model = 1'b0;
      check("R7 flag", {15'd0, tsd_o}, {15'd0, tsd_model});
      if (kill_now) check(mute_i ? "R5 mute" : "R7 shutdown", pack_sw(), 16'h0000);
      for (int i = 0; i < 8; i++) begin
        int  ch;
        logic up, lo, on;
        ch = i / 2;
        up = (i % 2 == 0) ? sw_a_o[ch] : sw_d_o[ch];
        lo = (i % 2 == 0) ? sw_b_o[ch] : sw_c_o[ch];
        on = up | lo;
        if (on && !prev_on[i]) begin
          check("R6 both-on", {15'd0, up & lo}, 16'h0000);
          check_ge("R6 gap", off_run[i], DEAD);
        end
        if (!on && prev_on[i] && !kill_now) check_ge("R8 pulse", on_run[i], MINPW);
        if (on) begin on_run[i]++; off_run[i] = 0; end
        else    begin off_run[i]++; on_run[i] = 0; end
        prev_on[i] = on;
      end
      tsd_prev = tsd_o;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    int seed;
    seed = $urandom(32'd4711);

    // R9: reset state and first cycles after release
    repeat (3) @(negedge clk);
    check("R9 reset sw", pack_sw(), 16'h0000);
    check("R9 reset tsd", {15'd0, tsd_o}, 16'h0000);
    rst_n = 1'b1;
    for (int k = 0; k < DEAD - 1; k++) begin
      @(negedge clk);
      check("R9 early", pack_sw(), 16'h0000);
    end
    settle_check("R3 R4 brake after reset");

    // R1..R4 truth table
    fwd_i = 3'b111; rev_i = 3'b000; spin_cmd_i = 2'b01; settle_check("R1 R4 forward");
    fwd_i = 3'b000; rev_i = 3'b111; spin_cmd_i = 2'b00; settle_check("R2 R4 reverse");
    fwd_i = 3'b111; rev_i = 3'b111; spin_cmd_i = 2'b11; settle_check("R3 R4 brake 11");
    fwd_i = 3'b000; rev_i = 3'b000; spin_cmd_i = 2'b10; settle_check("R3 R4 brake 00/open");
    fwd_i = 3'b101; rev_i = 3'b011; spin_cmd_i = 2'b00; settle_check("R1 R2 R3 R4 mixed");
    fwd_i = 3'b010; rev_i = 3'b100; spin_cmd_i = 2'b01; settle_check("R1 R2 R3 R4 mixed2");

    // R6: brake -> forward on channel 1, count the off gap on the OUT+ leg
    fwd_i = 3'b000; rev_i = 3'b000; settle_check("R3 pre-gap");
    fwd_i[0] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sw_a_o[1]) break;
      if (!sw_b_o[1]) cnt++;
    end
    check_ge("R6 directed gap", cnt, DEAD);
    check("R6 OUT- kept low", {15'd0, sw_c_o[1]}, 16'h0001);

    // R8: drop the command as soon as A appears
    fwd_i[0] = 1'b0;
    cnt = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sw_a_o[1]) cnt++;
      else break;
    end
    check_ge("R8 directed pulse", cnt, MINPW);
    settle_check("R3 after pulse");

    // R5: mute
    fwd_i = 3'b111; spin_cmd_i = 2'b01; settle_check("R1 pre-mute");
    mute_i = 1'b1;
    @(negedge clk);
    check("R5 mute next edge", pack_sw(), 16'h0000);
    fwd_i = 3'b000; spin_cmd_i = 2'b10;
    repeat (10) @(negedge clk);
    check("R5 mute over brake", pack_sw(), 16'h0000);
    mute_i = 1'b0;
    settle_check("R5 release brake");

    // R7: thermal hysteresis
    temp_i = 8'd149;
    repeat (3) @(negedge clk);
    check("R7 149 cold", {15'd0, tsd_o}, 16'h0000);
    check("R7 149 outputs", pack_sw(), expect_sw(fwd_i, rev_i, spin_cmd_i));
    temp_i = 8'd150;
    @(negedge clk);
    check("R7 150 set", {15'd0, tsd_o}, 16'h0001);
    @(negedge clk);
    check("R7 150 off", pack_sw(), 16'h0000);
    temp_i = 8'd131;
    repeat (5) @(negedge clk);
    check("R7 131 hold", {15'd0, tsd_o}, 16'h0001);
    check("R7 131 off", pack_sw(), 16'h0000);
    temp_i = 8'd130;
    @(negedge clk);
    check("R7 130 clear", {15'd0, tsd_o}, 16'h0000);
    settle_check("R7 recover");

    // Random segments
    for (int s = 0; s < 250; s++) begin
      logic [31:0] r;
      int len;
      r = $urandom;
      fwd_i      = r[2:0];
      rev_i      = r[5:3];
      spin_cmd_i = r[7:6];
      mute_i     = (r[11:8] == 4'd0);
      temp_i     = (r[15:12] == 4'd0) ? 8'(120 + ($urandom % 50)) : 8'd25;
      len        = 1 + ($urandom % 60);
      repeat (len) @(negedge clk);
      if (!mute_i && temp_i == 8'd25 && len >= SETTLE)
        check("R1 R2 R3 R4 random", pack_sw(), expect_sw(fwd_i, rev_i, spin_cmd_i));
    end
    mute_i = 1'b0;
    temp_i = 8'd25;
    settle_check("R1 R2 R3 R4 final");
    finish_run();
  end
endmodule